// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from eleven sources and presents at most one of them to the processor as a call request with a fixed vector address. Each source has a request flag and an enable bit, and a single master enable gates all of them. Seven sources arrive as one-cycle request pulses. Two come from external pins through a synchroniser and a programmable edge detector. Two are group flags, each of which collects two timer compare events that keep their own sub-flags and sub-enables.

A source can be taken when its flag, its enable and the master enable are all set. The lowest vector among those wins. The controller has three states. In `ST_IDLE` there is no call outstanding. `ST_WAIT` is used when a winner exists but the stack-full input is high. `ST_CALL` holds the call request and vector stable until the processor acknowledges. The transitions are:

- idle-to-call when a winner exists and the stack has room.
- idle-to-wait when a winner exists and the stack is full.
- wait-to-call when the stack frees up.
- wait-to-idle when the winner disappears.
- call-to-idle on acknowledge.

On that last transition the serviced flag and the master enable are cleared. Software reads and writes four registers through a simple select, write-strobe and data port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Slot i (0..10) has vector address 4*(i+1). The slots are OCP0=0, OCP1=1, INT0=2, group0=3, group1=4, time base 0=5, time base 1=6, A/D=7, EEPROM=8, INT1=9, low-voltage=10. The pulse input `src_pulse` bits 0..6 feed slots 0,1,5,6,7,8,10.
- R2: When several slots qualify, the one with the lowest slot number (lowest vector) is called.
- R3: A slot qualifies only when its flag bit, its enable bit and the master enable are all 1.
- R4: While `stack_full` is high, no call is raised and the flag stays set. The call is raised once `stack_full` falls.
- R5: When an acknowledged call is serviced, the master enable (register 1 bit 15) is cleared.
- R6: On service, the flag of the called slot is cleared. Sub-flags are never cleared by service, only by a software write.
- R7: Each pin has a 2-bit edge select: 00 off, 01 rising, 10 falling, 11 both. Pin 0 uses register 3 bits [5:4] and sets slot 2; pin 1 uses bits [7:6] and sets slot 9. Pins pass through two synchroniser flip-flops.
- R8: Sub-flags are bit0 timer0 compare P, bit1 timer0 compare A, bit2 timer1 compare P, bit3 timer1 compare A. A group flag (slot 3 for bits 0-1, slot 4 for bits 2-3) is set when one of its sub-sources becomes both flagged and sub-enabled.
- R9: A flag set event in the same cycle as a software write of that flag wins, so the flag ends set.
- R10: After reset there is no call and the vector is 0. Once raised, `call_req` and `call_vec` stay unchanged until `call_ack`.
- R11: Register map:
  - 0: flags [10:0].
  - 1: enables [10:0] and master [15].
  - 2: sub-flags [3:0].
  - 3: sub-enables [3:0] and edge selects [7:4].
  - All registers reset to 0, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | 7 | One-cycle request pulses of the directly vectored sources |
| sub_pulse | input | 4 | One-cycle timer compare events for the groups |
| ext_pin | input | 2 | Asynchronous external interrupt pins |
| stack_full | input | 1 | High while the processor stack cannot accept a call |
| call_ack | input | 1 | Processor accepts the outstanding call |
| sw_we | input | 1 | Register write strobe |
| sw_addr | input | 2 | Register select |
| sw_wdata | input | 16 | Register write data |
| sw_rdata | output | 16 | Read-back of the selected register |
| call_req | output | 1 | Call request to the processor |
| call_vec | output | 8 | Vector address of the outstanding call |

## Verification
The assertions assume that `call_ack` comes only while `call_req` is high, and that software never writes register 1 in the same cycle as an acknowledge. The bench pulses acknowledge only after it has seen a call. It changes the enables and the flags only with the master enable cleared, so a row's flags are never replaced under an outstanding call. The external pins are held low through reset and change only at falling clock edges, well apart from one another.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int NSRC     = 11;
    localparam int NDIR     = 7;
    localparam int NPIN     = 2;
    localparam int NGRP     = 2;
    localparam int NSUB_PER = 2;
    localparam int NSUB     = NGRP * NSUB_PER;
    localparam int IDX_W    = $clog2(NSRC);

    localparam int DIR_SLOT [NDIR] = '{0, 1, 5, 6, 7, 8, 10};
    localparam int PIN_SLOT [NPIN] = '{2, 9};
    localparam int GRP_SLOT [NGRP] = '{3, 4};

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CALL = 2'd2
    } ctl_state_t;

    typedef enum logic [1:0] {
        RA_FLAG = 2'd0,
        RA_ENAB = 2'd1,
        RA_SUBF = 2'd2,
        RA_SUBE = 2'd3
    } reg_addr_t;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det
    import irq_vec_pkg::*;
#(
    parameter int N_PINS      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_PINS-1:0]     pin_in,
    input  logic [2*N_PINS-1:0]   sel,
    output logic [N_PINS-1:0]     hit
);
    localparam int TOP = SYNC_STAGES - 1;

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic [SYNC_STAGES-1:0] sync_q;
        logic                   last_q;
        logic                   rise;
        logic                   fall;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q <= '0;
                last_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in[p]};
                last_q <= sync_q[TOP];
            end
        end

        assign rise = sync_q[TOP] & ~last_q;
        assign fall = ~sync_q[TOP] & last_q;

        always_comb begin
            unique case (edge_sel_t'(sel[2*p +: 2]))
                EDGE_OFF:  hit[p] = 1'b0;
                EDGE_RISE: hit[p] = rise;
                EDGE_FALL: hit[p] = fall;
                EDGE_BOTH: hit[p] = rise | fall;
                default:   hit[p] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/irq_group_flags.sv
module irq_group_flags
    import irq_vec_pkg::*;
#(
    parameter int N_GRP     = 2,
    parameter int N_PER_GRP = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_GRP*N_PER_GRP-1:0]    sub_req,
    input  logic                          wr_en,
    input  logic [N_GRP*N_PER_GRP-1:0]    wr_data,
    input  logic [N_GRP*N_PER_GRP-1:0]    sub_en,
    output logic [N_GRP*N_PER_GRP-1:0]    sub_flag,
    output logic [N_GRP-1:0]              grp_set
);
    localparam int NS = N_GRP * N_PER_GRP;

    logic [NS-1:0] flag_q;
    logic [NS-1:0] act_prev_q;
    logic [NS-1:0] active;
    logic [NS-1:0] newly;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q     <= '0;
            act_prev_q <= '0;
        end else begin
            flag_q     <= (wr_en ? wr_data : flag_q) | sub_req;
            act_prev_q <= active;
        end
    end

    assign active   = flag_q & sub_en;
    assign newly    = active & ~act_prev_q;
    assign sub_flag = flag_q;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_set[g] = |newly[g*N_PER_GRP +: N_PER_GRP];
    end

    // R6: sub-flags never fall without a software write
    assert_sub_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((sub_flag & $past(sub_flag)) == $past(sub_flag)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 11,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (any) begin
            assert_pick_lowest_R2: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_vec_pkg::*;
#(
    parameter int VEC_W       = 8,
    parameter int VEC_STEP    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NDIR-1:0]     src_pulse,
    input  logic [NSUB-1:0]     sub_pulse,
    input  logic [NPIN-1:0]     ext_pin,
    input  logic                stack_full,
    input  logic                call_ack,
    input  logic                sw_we,
    input  logic [1:0]          sw_addr,
    input  logic [DATA_W-1:0]   sw_wdata,
    output logic [DATA_W-1:0]   sw_rdata,
    output logic                call_req,
    output logic [VEC_W-1:0]    call_vec
);
    localparam int MASTER_BIT = DATA_W - 1;
    localparam int ESEL_LSB   = NSUB;
    localparam int ESEL_W     = 2 * NPIN;

    ctl_state_t        state_q, state_d;
    logic [NSRC-1:0]   flag_q, en_q, set_vec, pending, svc_mask, flag_base;
    logic              master_q;
    logic [ESEL_W-1:0] esel_q;
    logic [NSUB-1:0]   sube_q, subf;
    logic [NPIN-1:0]   pin_hit;
    logic [NGRP-1:0]   grp_set;
    logic              win_any, service;
    logic [IDX_W-1:0]  win_idx, cur_idx_q;
    logic              wr_flag, wr_enab, wr_subf, wr_sube;

    wire unused_wbits = ^sw_wdata[MASTER_BIT-1:NSRC];

    assign wr_flag = sw_we && (reg_addr_t'(sw_addr) == RA_FLAG);
    assign wr_enab = sw_we && (reg_addr_t'(sw_addr) == RA_ENAB);
    assign wr_subf = sw_we && (reg_addr_t'(sw_addr) == RA_SUBF);
    assign wr_sube = sw_we && (reg_addr_t'(sw_addr) == RA_SUBE);

    irq_edge_det #(.N_PINS(NPIN), .SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(ext_pin), .sel(esel_q), .hit(pin_hit)
    );

    irq_group_flags #(.N_GRP(NGRP), .N_PER_GRP(NSUB_PER)) u_grp (
        .clk(clk), .rst_n(rst_n), .sub_req(sub_pulse), .wr_en(wr_subf),
        .wr_data(sw_wdata[NSUB-1:0]), .sub_en(sube_q), .sub_flag(subf), .grp_set(grp_set)
    );

    always_comb begin
        set_vec = '0;
        for (int d = 0; d < NDIR; d++) set_vec[DIR_SLOT[d]] = src_pulse[d];
        for (int p = 0; p < NPIN; p++) set_vec[PIN_SLOT[p]] = pin_hit[p];
        for (int g = 0; g < NGRP; g++) set_vec[GRP_SLOT[g]] = grp_set[g];
    end

    assign pending = flag_q & en_q & {NSRC{master_q}};

    irq_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
        .req(pending), .any(win_any), .idx(win_idx)
    );

    assign service   = (state_q == ST_CALL) && call_ack;
    assign svc_mask  = service ? (NSRC'(1) << cur_idx_q) : '0;
    assign flag_base = wr_flag ? sw_wdata[NSRC-1:0] : flag_q;

    // Flag, enable and configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q   <= '0;
            en_q     <= '0;
            master_q <= 1'b0;
            esel_q   <= '0;
            sube_q   <= '0;
        end else begin
            flag_q <= (flag_base & ~svc_mask) | set_vec;
            if (wr_enab) begin
                en_q     <= sw_wdata[NSRC-1:0];
                master_q <= sw_wdata[MASTER_BIT];
            end
            if (service) master_q <= 1'b0;
            if (wr_sube) begin
                sube_q <= sw_wdata[NSUB-1:0];
                esel_q <= sw_wdata[ESEL_LSB +: ESEL_W];
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (win_any) state_d = stack_full ? ST_WAIT : ST_CALL;
            ST_WAIT: begin
                if (!win_any)        state_d = ST_IDLE;
                else if (!stack_full) state_d = ST_CALL;
            end
            ST_CALL: if (call_ack) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs: vector latched on entry to the call state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_idx_q <= '0;
            call_vec  <= '0;
        end else if (state_q != ST_CALL && state_d == ST_CALL) begin
            cur_idx_q <= win_idx;
            call_vec  <= VEC_W'((int'(win_idx) + 1) * VEC_STEP);
        end else if (service) begin
            call_vec  <= '0;
        end
    end

    assign call_req = (state_q == ST_CALL);

    always_comb begin
        sw_rdata = '0;
        unique case (reg_addr_t'(sw_addr))
            RA_FLAG: sw_rdata[NSRC-1:0] = flag_q;
            RA_ENAB: begin
                sw_rdata[NSRC-1:0]   = en_q;
                sw_rdata[MASTER_BIT] = master_q;
            end
            RA_SUBF: sw_rdata[NSUB-1:0] = subf;
            RA_SUBE: begin
                sw_rdata[NSUB-1:0]             = sube_q;
                sw_rdata[ESEL_LSB +: ESEL_W]   = esel_q;
            end
            default: sw_rdata = '0;
        endcase
    end

    assert_vec_grid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        call_req |-> ((int'(call_vec) % VEC_STEP) == 0 && int'(call_vec) >= VEC_STEP
                      && int'(call_vec) <= NSRC * VEC_STEP));

    assert_qualify_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> $past(master_q));

    assert_stack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> !$past(stack_full));

    assert_master_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && call_ack) |=> !master_q);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && src_pulse[0]) |=> flag_q[0]);

    assert_call_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !call_ack) |=> (call_req && $stable(call_vec)));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
    localparam int CLK_NS = 10;
    localparam int NROW   = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  src_pulse = '0;
    logic [3:0]  sub_pulse = '0;
    logic [1:0]  ext_pin = '0;
    logic        stack_full = 1'b0;
    logic        call_ack = 1'b0;
    logic        sw_we = 1'b0;
    logic [1:0]  sw_addr = '0;
    logic [15:0] sw_wdata = '0;
    logic [15:0] sw_rdata;
    logic        call_req;
    logic [7:0]  call_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    irq_vector_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .sub_pulse(sub_pulse),
        .ext_pin(ext_pin), .stack_full(stack_full), .call_ack(call_ack),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .call_req(call_req), .call_vec(call_vec)
    );

    // {flags[10:0], enables[10:0], expected vector (0 = no call)}
    localparam logic [29:0] ROWS [NROW] = '{
        {11'h001, 11'h7FF, 8'h04},   // R1 single slot 0
        {11'h7FF, 11'h7FF, 8'h04},   // R2 all pending
        {11'h7FE, 11'h7FF, 8'h08},   // R2 next in line
        {11'h600, 11'h7FF, 8'h28},   // R2 INT1 beats low-voltage
        {11'h400, 11'h400, 8'h2C},   // R1 last slot
        {11'h7FF, 11'h000, 8'h00},   // R3 nothing enabled
        {11'h0A0, 11'h080, 8'h20},   // R3 only A/D enabled
        {11'h010, 11'h7FF, 8'h14},   // R1 group 1
        {11'h100, 11'h100, 8'h24}    // R1 EEPROM
    };

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        sw_addr = a;
        #1;
        d = sw_rdata;
    endtask

    task automatic ack();
        @(negedge clk);
        call_ack = 1'b1;
        @(negedge clk);
        call_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        cyc(3);
        // R10 / R11: reset state
        check("R10 reset call_req", int'(call_req), 0);
        check("R10 reset call_vec", int'(call_vec), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R11 reset register", int'(v), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        cyc(2);

        // Table walk: R1, R2, R3, R5, R6
        for (int r = 0; r < NROW; r++) begin
            logic [10:0] fl, en, rem;
            logic [7:0]  ev;
            fl = ROWS[r][29:19];
            en = ROWS[r][18:8];
            ev = ROWS[r][7:0];
            wr(2'd1, 16'h0000);
            wr(2'd0, {5'b0, fl});
            wr(2'd1, {1'b1, 4'b0, en});
            cyc(3);
            check("R2 table call_req", int'(call_req), (ev != 0) ? 1 : 0);
            check("R1 table call_vec", int'(call_vec), int'(ev));
            if (ev != 0) begin
                ack();
                cyc(1);
                rem = fl & ~(11'(1) << ((ev >> 2) - 1));
                rd(2'd0, v);
                check("R6 serviced flag cleared", int'(v), int'(rem));
                rd(2'd1, v);
                check("R5 master cleared", int'(v), int'(en));
                check("R10 call dropped", int'(call_req), 0);
            end
        end

        // R7: edge selection, both pins
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h0010);              // pin0 rising
        ext_pin[0] = 1'b1; cyc(5);
        rd(2'd0, v); check("R7 pin0 rising sets slot 2", int'(v), 16'h0004);
        wr(2'd0, 16'h0000);
        ext_pin[0] = 1'b0; cyc(5);
        rd(2'd0, v); check("R7 pin0 falling ignored under rising", int'(v), 0);
        wr(2'd3, 16'h0020);              // pin0 falling
        ext_pin[0] = 1'b1; cyc(5);
        rd(2'd0, v); check("R7 pin0 rising ignored under falling", int'(v), 0);
        ext_pin[0] = 1'b0; cyc(5);
        rd(2'd0, v); check("R7 pin0 falling sets slot 2", int'(v), 16'h0004);
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h0000);              // off
        ext_pin[0] = 1'b1; cyc(5); ext_pin[0] = 1'b0; cyc(5);
        rd(2'd0, v); check("R7 select off ignores pin", int'(v), 0);
        wr(2'd3, 16'h00C0);              // pin1 both
        ext_pin[1] = 1'b1; cyc(5);
        rd(2'd0, v); check("R7 pin1 both, rise sets slot 9", int'(v), 16'h0200);
        wr(2'd0, 16'h0000);
        ext_pin[1] = 1'b0; cyc(5);
        rd(2'd0, v); check("R7 pin1 both, fall sets slot 9", int'(v), 16'h0200);

        // R11: register 3 layout read-back
        rd(2'd3, v); check("R11 edge select readback", int'(v), 16'h00C0);

        // R8 / R6: groups and sub-flags
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h0002);              // sub-enable timer0 compare A only
        @(negedge clk); sub_pulse = 4'b0110;
        @(negedge clk); sub_pulse = 4'b0000;
        cyc(3);
        rd(2'd2, v); check("R8 sub-flags set", int'(v), 16'h0006);
        rd(2'd0, v); check("R8 only group0 flagged", int'(v), 16'h0008);
        wr(2'd1, 16'h8008);
        cyc(3);
        check("R8 group0 call vector", int'(call_vec), 16'h10);
        ack(); cyc(1);
        rd(2'd0, v); check("R6 group flag cleared", int'(v), 0);
        rd(2'd2, v); check("R6 sub-flags kept", int'(v), 16'h0006);
        rd(2'd1, v); check("R5 master cleared after group", int'(v), 16'h0008);
        wr(2'd2, 16'h0000);
        rd(2'd2, v); check("R6 sub-flags cleared by write", int'(v), 0);

        // R4 / R10: stack full hold-off and call hold
        wr(2'd3, 16'h0000);
        stack_full = 1'b1;
        wr(2'd0, 16'h0001);
        wr(2'd1, 16'h8001);
        cyc(4);
        check("R4 no call while stack full", int'(call_req), 0);
        rd(2'd0, v); check("R4 flag stays pending", int'(v), 16'h0001);
        stack_full = 1'b0;
        cyc(3);
        check("R4 call after stack frees", int'(call_req), 1);
        check("R4 vector after stack frees", int'(call_vec), 16'h04);
        stack_full = 1'b1;
        cyc(4);
        check("R10 call held without ack", int'(call_req), 1);
        check("R10 vector held without ack", int'(call_vec), 16'h04);
        stack_full = 1'b0;
        ack(); cyc(1);
        check("R10 vector returns to 0", int'(call_vec), 0);

        // R9: set beats software clear
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0002);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = 2'd0; sw_wdata = 16'h0000; src_pulse = 7'b0000001;
        @(negedge clk);
        sw_we = 1'b0; src_pulse = '0;
        rd(2'd0, v); check("R9 set wins over write", int'(v), 16'h0001);
        wr(2'd0, 16'h0000);
        rd(2'd0, v); check("R11 flags cleared by write", int'(v), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule